// File: doc/BRIEF.md
# Quarter-Wave Sine/Cosine Lookup Generator

This block turns a 12-bit phase word into a signed 16-bit sine or cosine sample. A single bit chosen with each phase word selects the function. Only one quarter of a sine period is held in a table, and the other three quarters are rebuilt from the wave's symmetry. The table address is reflected for the falling quarters, and the sign of the value read is flipped for the negative half. The phase circle is split into 4096 equal steps.

The table is filled when the design is elaborated, using a half-step sample offset. Because of that offset, a reflected address reads exactly the mirror value, and every result lies inside the symmetric range from -32767 to +32767. The work is split over three registers: address decode, table read and sign restore. No adder sits in series with the memory read, so the block accepts a new phase word on every clock and answers three clocks later.

Top module: `sincos_quarter_lut`

## Requirements
- R1: While and directly after synchronous reset, `out_valid` is 0 and `sample` is 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, three clock edges later. No other cycle asserts `out_valid`.
- R3: Let T(k) = round(32767 * sin((k + 0.5) * pi / 2048)) for k in 0..1023. With `cos_sel` = 0, a phase 0..1023 (bits 11:10 = 00) gives T(phase).
- R4: With `cos_sel` = 0, a phase 1024 + i (bits 11:10 = 01) gives T(1023 - i). The reflection inverts the low 10 phase bits.
- R5: With `cos_sel` = 0, a phase 2048 + i (bits 11:10 = 10) gives -T(i), negated in two's complement.
- R6: With `cos_sel` = 0, a phase 3072 + i (bits 11:10 = 11) gives -T(1023 - i).
- R7: With `cos_sel` = 1, the result equals the sine result for phase (phase + 1024) mod 4096. This adds one to the quadrant code.
- R8: `sample` never takes the value -32768. Phases 1023 and 1024 give +32767 for sine, phases 3071 and 3072 give -32767, and phase 0 gives +25.
- R9: While `out_valid` is 0, `sample` keeps its previous value.
- R10: Phase words and `cos_sel` may change on every cycle. Back-to-back inputs give back-to-back correct results in input order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase word and select are valid this cycle |
| phase | input | 12 | Phase, 4096 steps per period; bits 11:10 are the quadrant |
| cos_sel | input | 1 | 0 selects sine, 1 selects cosine |
| out_valid | output | 1 | `sample` carries a new result |
| sample | output | 16 | Signed result in 1.15 fixed point |

## Verification
Address reflection and output negation can fall on the same sample. This happens in the fourth quadrant for sine and in the third quadrant for cosine, where an inverted index must meet a negated table word. The bench provokes this with continuous streams in which the phase crosses every quadrant boundary, and it toggles the function select on every cycle. Each streamed result is judged against a bench-side model built from the quadrant rules. The peak entries at the quadrant edges are compared against their exact expected values.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

   typedef logic [1:0] quad_t;

   // Quarter-wave entry k of a table with 2**idx_w entries and mag_w magnitude bits.
   function automatic int unsigned qw_entry(input int k, input int idx_w, input int mag_w);
      real full_scale;
      real angle;
      real val;
      full_scale = real'((1 << mag_w) - 1);
      angle      = (real'(k) + 0.5) * 3.14159265358979323846 / real'(1 << (idx_w + 1));
      val        = full_scale * $sin(angle) + 0.5;
      return $rtoi(val);
   endfunction

endpackage

// File: rtl/sincos_quad_decode.sv
module sincos_quad_decode
   import sincos_pkg::*;
#(
   parameter int PHASE_W = 12,
   localparam int IDX_W  = PHASE_W - 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               vld_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               cos_i,
   output logic               vld_o,
   output logic [IDX_W-1:0]   idx_o,
   output logic               neg_o
);

   quad_t quad;

   // Cosine advances the quadrant by one, modulo four.
   always_comb quad = phase_i[PHASE_W-1 -: 2] + quad_t'(cos_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         idx_o <= '0;
         neg_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         idx_o <= quad[0] ? ~phase_i[IDX_W-1:0] : phase_i[IDX_W-1:0];
         neg_o <= quad[1];
      end
   end

   assert_neg_flag_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> neg_o == ($past(phase_i[PHASE_W-1]) ^ ($past(cos_i) & $past(phase_i[PHASE_W-2]))));

   assert_mirror_R4: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (idx_o ^ $past(phase_i[IDX_W-1:0])) == {IDX_W{$past(phase_i[PHASE_W-2]) ^ $past(cos_i)}});

endmodule

// File: rtl/sincos_quarter_rom.sv
module sincos_quarter_rom
   import sincos_pkg::*;
#(
   parameter int IDX_W   = 10,
   parameter int MAG_W   = 15,
   localparam int DEPTH  = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vld_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             neg_i,
   output logic             vld_o,
   output logic [MAG_W-1:0] mag_o,
   output logic             neg_o
);

   logic [MAG_W-1:0] table_w [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_entry
      assign table_w[k] = MAG_W'(qw_entry(k, IDX_W, MAG_W));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         mag_o <= '0;
         neg_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         mag_o <= table_w[idx_i];
         neg_o <= neg_i;
      end
   end

   assert_valid_chain_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> vld_o == $past(vld_i));

   assert_flag_carry_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> neg_o == $past(neg_i));

endmodule

// File: rtl/sincos_sign_restore.sv
module sincos_sign_restore #(
   parameter int MAG_W    = 15,
   localparam int SAMPLE_W = MAG_W + 1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       vld_i,
   input  logic [MAG_W-1:0]           mag_i,
   input  logic                       neg_i,
   output logic                       vld_o,
   output logic signed [SAMPLE_W-1:0] sample_o
);

   logic signed [SAMPLE_W-1:0] pos_val;

   always_comb pos_val = {1'b0, mag_i};

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o    <= 1'b0;
         sample_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) sample_o <= neg_i ? -pos_val : pos_val;
      end
   end

   assert_no_min_R8: assert property (@(posedge clk) disable iff (rst)
      sample_o != {1'b1, {MAG_W{1'b0}}});

   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !vld_o |-> $stable(sample_o));

   assert_sign_R6: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && vld_o && $past(neg_i) |-> sample_o + $signed({1'b0, $past(mag_i)}) == 0);

endmodule

// File: rtl/sincos_quarter_lut.sv
module sincos_quarter_lut #(
   parameter int PHASE_W  = 12,
   parameter int SAMPLE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [PHASE_W-1:0]         phase,
   input  logic                       cos_sel,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] sample
);

   localparam int IDX_W = PHASE_W - 2;
   localparam int MAG_W = SAMPLE_W - 1;

   if (PHASE_W < 4 || PHASE_W > 14) begin : g_bad_phase
      $error("PHASE_W must lie in 4..14");
   end
   if (SAMPLE_W < 4 || SAMPLE_W > 31) begin : g_bad_sample
      $error("SAMPLE_W must lie in 4..31");
   end

   logic             s1_vld, s1_neg;
   logic [IDX_W-1:0] s1_idx;
   logic             s2_vld, s2_neg;
   logic [MAG_W-1:0] s2_mag;

   sincos_quad_decode #(.PHASE_W(PHASE_W)) u_decode (
      .clk(clk), .rst(rst), .vld_i(in_valid), .phase_i(phase), .cos_i(cos_sel),
      .vld_o(s1_vld), .idx_o(s1_idx), .neg_o(s1_neg)
   );

   sincos_quarter_rom #(.IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
      .clk(clk), .rst(rst), .vld_i(s1_vld), .idx_i(s1_idx), .neg_i(s1_neg),
      .vld_o(s2_vld), .mag_o(s2_mag), .neg_o(s2_neg)
   );

   sincos_sign_restore #(.MAG_W(MAG_W)) u_sign (
      .clk(clk), .rst(rst), .vld_i(s2_vld), .mag_i(s2_mag), .neg_i(s2_neg),
      .vld_o(out_valid), .sample_o(sample)
   );

   assert_reset_R1: assert property (@(posedge clk)
      $past(rst) |-> !out_valid && sample == 0);

endmodule

// File: tb/sincos_quarter_lut_bench.sv
`timescale 1ns/1ps
module sincos_quarter_lut_bench;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               in_valid = 1'b0;
   logic [11:0]        phase = '0;
   logic               cos_sel = 1'b0;
   logic               out_valid;
   logic signed [15:0] sample;

   int checks = 0;
   int errors = 0;

   logic  hv   [3];
   int    hexp [3];
   int    hph  [3];
   string htag [3];
   int    last_sample = 0;

   always #10 clk = ~clk;

   sincos_quarter_lut u_sincos_quarter_lut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .phase(phase),
      .cos_sel(cos_sel), .out_valid(out_valid), .sample(sample)
   );

   function automatic int tab(input int k);
      return $rtoi(32767.0 * $sin((real'(k) + 0.5) * 3.14159265358979323846 / 2048.0) + 0.5);
   endfunction

   // Sine model from the quadrant rules R3..R6.
   function automatic int sine_ref(input int p);
      int i;
      i = p % 1024;
      case ((p / 1024) % 4)
         0:       return tab(i);
         1:       return tab(1023 - i);
         2:       return -tab(i);
         default: return -tab(1023 - i);
      endcase
   endfunction

   function automatic string quad_tag(input int p);
      case ((p / 1024) % 4)
         0:       return "R3";
         1:       return "R4";
         2:       return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input int got, input int exp, input int ph);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s phase=%0d got %0d expected %0d", tag, ph, got, exp);
      end
   endtask

   // One cycle at the falling edge: judge the output due now, then drive the next input.
   task automatic step(input logic v, input logic sel, input int ph, input int exp, input string tag);
      if (hv[2]) begin
         check({"R2 ", htag[2]}, int'(out_valid), 1, hph[2]);
         check(htag[2], int'(sample), hexp[2], hph[2]);
      end else begin
         check("R2 idle", int'(out_valid), 0, -1);
         check("R9 hold", int'(sample), last_sample, -1);
      end
      last_sample = int'(sample);
      for (int j = 2; j > 0; j--) begin
         hv[j] = hv[j-1]; hexp[j] = hexp[j-1]; hph[j] = hph[j-1]; htag[j] = htag[j-1];
      end
      hv[0] = v; hexp[0] = exp; hph[0] = ph; htag[0] = tag;
      in_valid = v;
      cos_sel  = sel;
      phase    = 12'(ph);
      @(negedge clk);
   endtask

   task automatic flush();
      for (int j = 0; j < 4; j++) step(1'b0, 1'b0, 0, 0, "");
   endtask

   task automatic test_reset();
      for (int j = 0; j < 3; j++) hv[j] = 1'b0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 valid", int'(out_valid), 0, -1);
      check("R1 sample", int'(sample), 0, -1);
      rst = 1'b0;
      @(negedge clk);
      check("R1 valid after", int'(out_valid), 0, -1);
      check("R1 sample after", int'(sample), 0, -1);
      last_sample = 0;
   endtask

   task automatic test_sine_sweep();
      for (int p = 0; p < 4096; p += 13) step(1'b1, 1'b0, p, sine_ref(p), quad_tag(p));
      flush();
   endtask

   task automatic test_cosine();
      for (int p = 5; p < 4096; p += 29) step(1'b1, 1'b1, p, sine_ref((p + 1024) % 4096), "R7");
      flush();
   endtask

   task automatic test_peaks();
      step(1'b1, 1'b0, 1023, 32767, "R8 peak");
      step(1'b1, 1'b0, 1024, 32767, "R8 peak");
      step(1'b1, 1'b0, 3071, -32767, "R8 trough");
      step(1'b1, 1'b0, 3072, -32767, "R8 trough");
      step(1'b1, 1'b0, 0, 25, "R8 zero");
      step(1'b1, 1'b1, 0, 32767, "R7 cos0");
      step(1'b1, 1'b1, 2048, -32767, "R7 cos pi");
      flush();
   endtask

   task automatic test_hold();
      step(1'b1, 1'b0, 700, sine_ref(700), "R3");
      for (int j = 0; j < 6; j++) step(1'b0, 1'b1, 3000 + j, 0, "");
      step(1'b1, 1'b1, 2500, sine_ref(3524), "R7");
      step(1'b0, 1'b0, 100, 0, "");
      step(1'b1, 1'b0, 3500, sine_ref(3500), "R6");
      flush();
   endtask

   task automatic test_stream();
      int p = 1000;
      for (int j = 0; j < 300; j++) begin
         logic sel = 1'(j);
         int e = sel ? sine_ref((p + 1024) % 4096) : sine_ref(p);
         step(1'b1, sel, p, e, "R10");
         p = (p + 37) % 4096;
      end
      flush();
   endtask

   initial begin
      @(negedge clk);
      test_reset();
      test_sine_sweep();
      test_cosine();
      test_peaks();
      test_hold();
      test_stream();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule